// File: doc/BRIEF.md
# Descriptor-Driven Stripe Parity Engine

This engine carries out one parity job in host memory. It is given a pointer to a 32-byte job descriptor. It reads that descriptor with a tagged cacheline read and byte-reverses the four little-endian 64-bit fields it holds. It then works through the job one 128-byte line at a time. For each line it reads the matching line of two source stripes, XORs them, and writes the result to the parity buffer. When the job size is used up, it writes a completion flag next to the descriptor and goes quiet until it is reset.

The engine talks to the host through four ports:
- a command port, which carries an opcode, a tag, a size and an address, each with an odd-parity bit;
- an inbound beat port, on which the host delivers read data as two 512-bit halves of a line;
- an outbound fetch port, on which the host pulls write data by tag and half, one cycle after it asks;
- a response port, keyed by tag.

Every command carries a fixed tag that names its purpose. Each wait state leaves only when the response for its own tag has been seen.

Top module: `xor_stripe_engine`

## Requirements
- R1: After reset, `cmd_valid` is low. The first enabled cycle issues a descriptor read: code 0x0A (read-no-allocate), tag 0, size 32, at `desc_ptr`. That command is valid for exactly one cycle.
- R2: The descriptor is taken from the beat with tag 0 and half address 0. Its fields are size in data bits [511:448], stripe-one pointer in [447:384], stripe-two pointer in [383:320] and parity pointer in [319:256]. Each field is byte-reversed before use, and bits [255:0] are ignored.
- R3: Once the tag-0 response arrives, the engine issues two reads on back-to-back cycles: code 0x0A, size 128, tag 1 at the stripe-one pointer, then tag 2 at the stripe-two pointer.
- R4: A beat with half address 0 fills the lower half of a line and half address 1 fills the upper half. When the same tag and half arrive more than once, the last valid beat is the one kept.
- R5: After the responses for tags 1 and 2 have both arrived, the engine issues a write: code 0x0D (write-no-allocate), tag 3, size 128, at the parity pointer.
- R6: A fetch with tag 3 and half h returns stripe-one half h XOR stripe-two half h on `rbuf_data` in the following cycle. `rbuf_latency` reads 1.
- R7: Each further line advances all three pointers by 128 bytes. The number of lines is the size divided by 128, rounded up, with a minimum of one line (a size of 0 still processes one line).
- R8: After the tag-3 response for the last line, the engine writes the done flag: code 0x0D, tag 4, size 8, at `desc_ptr` + 32. A tag-4 fetch of half 0 returns the value 1 and half 1 returns 0. After that, no command is issued until reset.
- R9: A response whose tag differs from the awaited one does not advance the engine.
- R10: `cmd_code_par`, `cmd_tag_par`, `cmd_addr_par` and `rbuf_par` make the count of ones in their field odd. `cmd_abort` and `cmd_ctx` are 0.
- R11: While `enable` is low, no command is issued and the state does not advance. Responses that arrive meanwhile are remembered.
- R12: Raising `rst` in the middle of a job returns the engine to its start state. The next enabled cycle issues a new descriptor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows state progress |
| desc_ptr | input | 64 | Descriptor base address |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 8 | Command opcode |
| cmd_code_par | output | 1 | Odd parity of opcode |
| cmd_tag | output | 8 | Command tag |
| cmd_tag_par | output | 1 | Odd parity of tag |
| cmd_size | output | 12 | Transfer size in bytes |
| cmd_addr | output | 64 | Transfer address |
| cmd_addr_par | output | 1 | Odd parity of address |
| cmd_abort | output | 3 | Abort mode, tied 0 |
| cmd_ctx | output | 16 | Context handle, tied 0 |
| wbuf_valid | input | 1 | Inbound beat strobe |
| wbuf_tag | input | 8 | Tag of inbound beat |
| wbuf_addr | input | 6 | Half address of inbound beat |
| wbuf_data | input | 512 | Inbound beat data |
| rbuf_req | input | 1 | Outbound fetch strobe |
| rbuf_tag | input | 8 | Tag of the fetch |
| rbuf_addr | input | 6 | Half address of the fetch |
| rbuf_data | output | 512 | Fetched data, one cycle later |
| rbuf_par | output | 1 | Odd parity of fetched data |
| rbuf_latency | output | 4 | Fetch latency, reads 1 |
| rsp_valid | input | 1 | Response strobe |
| rsp_tag | input | 8 | Tag of the response |

## Verification
The embedded properties take for granted that the host pulses each input strobe for single cycles. They also assume that `rsp_tag` and `rbuf_tag` only name tags that are in use, and that no fetch is made while the engine is being reset. The bench host model keeps to these rules. It answers each logged command in order, after a short delay, with its beats followed by one response. It only fetches write data for commands it has actually seen, and it drives every input on the falling edge. The bench also injects tags the engine is not waiting for, repeated beats and pauses in `enable`, all of which the properties allow.

// File: rtl/xse_pkg.sv
package xse_pkg;

    parameter int unsigned ADDR_W     = 64;
    parameter int unsigned HALF_W     = 512;
    parameter int unsigned TAG_W      = 8;
    parameter int unsigned CODE_W     = 8;
    parameter int unsigned SIZE_W     = 12;
    parameter int unsigned BADDR_W    = 6;
    parameter int unsigned FIELD_W    = 64;
    parameter int unsigned BEATS      = 2;
    parameter int unsigned LINE_BYTES = 128;
    parameter int unsigned DESC_BYTES = 32;
    parameter int unsigned FLAG_BYTES = 8;
    parameter int unsigned NTAGS      = 5;
    parameter int unsigned NFIELDS    = 4;

    localparam logic [CODE_W-1:0] OP_RD_NA = 8'h0A;
    localparam logic [CODE_W-1:0] OP_WR_NA = 8'h0D;

    typedef enum logic [TAG_W-1:0] {
        TAG_DESC = 8'd0,
        TAG_S1   = 8'd1,
        TAG_S2   = 8'd2,
        TAG_PAR  = 8'd3,
        TAG_DONE = 8'd4
    } tag_e;

    typedef enum logic [3:0] {
        S_START,
        S_WAIT_DESC,
        S_REQ_S1,
        S_REQ_S2,
        S_WAIT_STRIPES,
        S_WRITE_PAR,
        S_WAIT_PAR,
        S_WRITE_DONE,
        S_WAIT_DONE,
        S_HALT
    } eng_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] size;
        logic [ADDR_W-1:0]  s1;
        logic [ADDR_W-1:0]  s2;
        logic [ADDR_W-1:0]  par;
    } job_desc_t;

    typedef struct packed {
        logic               valid;
        logic [CODE_W-1:0]  code;
        tag_e               tag;
        logic [SIZE_W-1:0]  size;
        logic [ADDR_W-1:0]  addr;
    } host_cmd_t;

    function automatic logic [FIELD_W-1:0] byte_rev(input logic [FIELD_W-1:0] v);
        logic [FIELD_W-1:0] r;
        for (int b = 0; b < FIELD_W / 8; b++) begin
            r[8*b +: 8] = v[FIELD_W - 8*(b+1) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/xse_desc_unpack.sv
module xse_desc_unpack
    import xse_pkg::*;
#(
    parameter int unsigned BEAT_W = HALF_W,
    parameter int unsigned FW     = FIELD_W,
    parameter int unsigned NF     = NFIELDS
) (
    input  logic [BEAT_W-1:0] beat,
    output job_desc_t         fields
);
    logic [NF-1:0][FW-1:0] f;

    // Field k sits k words below the top of the beat; the first field lands in the struct MSBs.
    for (genvar k = 0; k < NF; k++) begin : g_field
        assign f[NF-1-k] = byte_rev(beat[BEAT_W-1-FW*k -: FW]);
    end

    assign fields = job_desc_t'(f);
endmodule

// File: rtl/xse_line_buf.sv
module xse_line_buf
    import xse_pkg::*;
#(
    parameter int unsigned HW = HALF_W,
    parameter int unsigned NB = BEATS,
    parameter int unsigned AW = BADDR_W,
    parameter int unsigned TW = TAG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [TW-1:0] wr_tag,
    input  logic [AW-1:0] wr_addr,
    input  logic [HW-1:0] wr_data,
    input  logic          rd_req,
    input  logic [TW-1:0] rd_tag,
    input  logic [AW-1:0] rd_addr,
    output logic [HW-1:0] rd_data
);
    localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [HW-1:0] FLAG_WORD = HW'(1);

    logic [HW-1:0] s1_q [NB];
    logic [HW-1:0] s2_q [NB];

    // Each half of each stripe line keeps the last matching beat.
    for (genvar b = 0; b < NB; b++) begin : g_half
        always_ff @(posedge clk) begin
            if (wr_valid && wr_addr == AW'(b)) begin
                if (wr_tag == TAG_S1) s1_q[b] <= wr_data;
                if (wr_tag == TAG_S2) s2_q[b] <= wr_data;
            end
        end
    end

    logic              rd_in_range;
    logic [IDX_W-1:0]  rd_idx;

    assign rd_in_range = (rd_addr < AW'(NB));
    assign rd_idx      = rd_addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_req) begin
            if (rd_tag == TAG_PAR && rd_in_range)
                rd_data <= s1_q[rd_idx] ^ s2_q[rd_idx];
            else if (rd_tag == TAG_DONE && rd_addr == '0)
                rd_data <= FLAG_WORD;
            else
                rd_data <= '0;
        end
    end

    // R6: fetched data only changes in answer to a fetch
    a_r6_fetch_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(rd_data));
endmodule

// File: rtl/xse_seq.sv
module xse_seq
    import xse_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned TW = TAG_W,
    parameter int unsigned NT = NTAGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [AW-1:0] desc_ptr,
    input  logic          desc_beat,
    input  job_desc_t     desc_in,
    input  logic          rsp_valid,
    input  logic [TW-1:0] rsp_tag,
    output host_cmd_t     cmd
);
    localparam logic [AW-1:0] LINE_STEP = AW'(LINE_BYTES);
    localparam logic [AW-1:0] FLAG_OFS  = AW'(DESC_BYTES);

    eng_state_e     state, nxt;
    logic [AW-1:0]  remaining, p_s1, p_s2, p_par, base;
    logic [NT-1:0]  seen, hit;
    logic           iss, step;
    host_cmd_t      iss_cmd;

    // A tag counts as answered if its response came earlier or comes now.
    always_comb begin
        for (int t = 0; t < NT; t++)
            hit[t] = seen[t] | (rsp_valid && rsp_tag == TW'(t));
    end

    always_comb begin
        nxt     = state;
        iss     = 1'b0;
        step    = 1'b0;
        iss_cmd = '{valid: 1'b1, code: OP_RD_NA, tag: TAG_DESC, size: '0, addr: '0};
        if (enable) begin
            unique case (state)
                S_START: begin
                    iss          = 1'b1;
                    iss_cmd.size = SIZE_W'(DESC_BYTES);
                    iss_cmd.addr = desc_ptr;
                    nxt          = S_WAIT_DESC;
                end
                S_WAIT_DESC: if (hit[int'(TAG_DESC)]) nxt = S_REQ_S1;
                S_REQ_S1: begin
                    iss          = 1'b1;
                    iss_cmd.tag  = TAG_S1;
                    iss_cmd.size = SIZE_W'(LINE_BYTES);
                    iss_cmd.addr = p_s1;
                    nxt          = S_REQ_S2;
                end
                S_REQ_S2: begin
                    iss          = 1'b1;
                    iss_cmd.tag  = TAG_S2;
                    iss_cmd.size = SIZE_W'(LINE_BYTES);
                    iss_cmd.addr = p_s2;
                    nxt          = S_WAIT_STRIPES;
                end
                S_WAIT_STRIPES:
                    if (hit[int'(TAG_S1)] && hit[int'(TAG_S2)]) nxt = S_WRITE_PAR;
                S_WRITE_PAR: begin
                    iss          = 1'b1;
                    iss_cmd.code = OP_WR_NA;
                    iss_cmd.tag  = TAG_PAR;
                    iss_cmd.size = SIZE_W'(LINE_BYTES);
                    iss_cmd.addr = p_par;
                    nxt          = S_WAIT_PAR;
                end
                S_WAIT_PAR: begin
                    if (hit[int'(TAG_PAR)]) begin
                        if (remaining <= LINE_STEP) begin
                            nxt = S_WRITE_DONE;
                        end else begin
                            step = 1'b1;
                            nxt  = S_REQ_S1;
                        end
                    end
                end
                S_WRITE_DONE: begin
                    iss          = 1'b1;
                    iss_cmd.code = OP_WR_NA;
                    iss_cmd.tag  = TAG_DONE;
                    iss_cmd.size = SIZE_W'(FLAG_BYTES);
                    iss_cmd.addr = base + FLAG_OFS;
                    nxt          = S_WAIT_DONE;
                end
                S_WAIT_DONE: if (hit[int'(TAG_DONE)]) nxt = S_HALT;
                S_HALT: nxt = S_HALT;
                default: nxt = S_START;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_START;
            cmd       <= '0;
            seen      <= '0;
            remaining <= '0;
            p_s1      <= '0;
            p_s2      <= '0;
            p_par     <= '0;
            base      <= '0;
        end else begin
            state     <= nxt;
            cmd.valid <= iss;
            if (iss) cmd <= iss_cmd;
            for (int t = 0; t < NT; t++) begin
                if (rsp_valid && rsp_tag == TW'(t)) seen[t] <= 1'b1;
                if (iss && iss_cmd.tag == tag_e'(t)) seen[t] <= 1'b0;
            end
            if (iss && state == S_START) base <= desc_ptr;
            if (state == S_WAIT_DESC && desc_beat) begin
                remaining <= desc_in.size;
                p_s1      <= desc_in.s1;
                p_s2      <= desc_in.s2;
                p_par     <= desc_in.par;
            end else if (step) begin
                remaining <= remaining - LINE_STEP;
                p_s1      <= p_s1 + LINE_STEP;
                p_s2      <= p_s2 + LINE_STEP;
                p_par     <= p_par + LINE_STEP;
            end
        end
    end

    // R1: the descriptor read strobe lasts a single cycle
    a_r1_desc_single: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.tag == TAG_DESC) |=> !cmd.valid);
    // R3: the stripe-two read follows the stripe-one read directly
    a_r3_s2_after_s1: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.tag == TAG_S1 && enable) |=> (cmd.valid && cmd.tag == TAG_S2));
    // R11: no command appears after a disabled cycle
    a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !cmd.valid);
    // R8: a halted engine issues nothing
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_HALT) |-> !cmd.valid);
    // R9: the parity wait holds until its own tag is answered
    a_r9_par_wait: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT_PAR && !seen[int'(TAG_PAR)] &&
         !(rsp_valid && rsp_tag == TAG_PAR)) |=> (state == S_WAIT_PAR));
endmodule

// File: rtl/xor_stripe_engine.sv
module xor_stripe_engine
    import xse_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [ADDR_W-1:0]  desc_ptr,
    output logic               cmd_valid,
    output logic [CODE_W-1:0]  cmd_code,
    output logic               cmd_code_par,
    output logic [TAG_W-1:0]   cmd_tag,
    output logic               cmd_tag_par,
    output logic [SIZE_W-1:0]  cmd_size,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic               cmd_addr_par,
    output logic [2:0]         cmd_abort,
    output logic [15:0]        cmd_ctx,
    input  logic               wbuf_valid,
    input  logic [TAG_W-1:0]   wbuf_tag,
    input  logic [BADDR_W-1:0] wbuf_addr,
    input  logic [HALF_W-1:0]  wbuf_data,
    input  logic               rbuf_req,
    input  logic [TAG_W-1:0]   rbuf_tag,
    input  logic [BADDR_W-1:0] rbuf_addr,
    output logic [HALF_W-1:0]  rbuf_data,
    output logic               rbuf_par,
    output logic [3:0]         rbuf_latency,
    input  logic               rsp_valid,
    input  logic [TAG_W-1:0]   rsp_tag
);
    job_desc_t  desc_fields;
    host_cmd_t  cmd;
    logic       desc_beat;

    assign desc_beat = wbuf_valid && wbuf_tag == TAG_DESC && wbuf_addr == '0;

    xse_desc_unpack u_unpack (
        .beat   (wbuf_data),
        .fields (desc_fields)
    );

    xse_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .desc_ptr  (desc_ptr),
        .desc_beat (desc_beat),
        .desc_in   (desc_fields),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .cmd       (cmd)
    );

    xse_line_buf u_lines (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wbuf_valid),
        .wr_tag   (wbuf_tag),
        .wr_addr  (wbuf_addr),
        .wr_data  (wbuf_data),
        .rd_req   (rbuf_req),
        .rd_tag   (rbuf_tag),
        .rd_addr  (rbuf_addr),
        .rd_data  (rbuf_data)
    );

    assign cmd_valid    = cmd.valid;
    assign cmd_code     = cmd.code;
    assign cmd_tag      = cmd.tag;
    assign cmd_size     = cmd.size;
    assign cmd_addr     = cmd.addr;
    assign cmd_code_par = ~^cmd.code;
    assign cmd_tag_par  = ~^cmd.tag;
    assign cmd_addr_par = ~^cmd.addr;
    assign rbuf_par     = ~^rbuf_data;
    assign cmd_abort    = '0;
    assign cmd_ctx      = '0;
    assign rbuf_latency = 4'd1;
endmodule

// File: tb/xor_stripe_engine_tb_top.sv
`timescale 1ns/1ps
module xor_stripe_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enable = 1'b0;
    logic [63:0]  desc_ptr = '0;
    logic         cmd_valid, cmd_code_par, cmd_tag_par, cmd_addr_par;
    logic [7:0]   cmd_code, cmd_tag;
    logic [11:0]  cmd_size;
    logic [63:0]  cmd_addr;
    logic [2:0]   cmd_abort;
    logic [15:0]  cmd_ctx;
    logic         wbuf_valid = 1'b0;
    logic [7:0]   wbuf_tag = '0;
    logic [5:0]   wbuf_addr = '0;
    logic [511:0] wbuf_data = '0;
    logic         rbuf_req = 1'b0;
    logic [7:0]   rbuf_tag = '0;
    logic [5:0]   rbuf_addr = '0;
    logic [511:0] rbuf_data;
    logic         rbuf_par;
    logic [3:0]   rbuf_latency;
    logic         rsp_valid = 1'b0;
    logic [7:0]   rsp_tag = '0;

    always #4 clk = ~clk;

    xor_stripe_engine dut_i (.*);

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] swap8(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[56 - 8*b +: 8];
        return r;
    endfunction

    function automatic logic [511:0] line_data(input logic [63:0] a, input int h);
        logic [511:0] d;
        for (int i = 0; i < 16; i++)
            d[32*i +: 32] = a[31:0] ^ (32'h9e3779b9 * (i + 1)) ^ (h != 0 ? 32'hffff0000 : 32'h0000ffff) ^ a[63:32];
        return d;
    endfunction

    // Command log filled by the monitor.
    logic [7:0]   lg_code [256];
    logic [7:0]   lg_tag  [256];
    logic [11:0]  lg_size [256];
    logic [63:0]  lg_addr [256];
    bit           lg_ok   [256];
    logic [511:0] lg_wd0  [256];
    logic [511:0] lg_wd1  [256];
    int n_cmds = 0;
    int srv_head = 0;
    bit srv_busy = 0;

    logic [63:0] tb_size, tb_s1, tb_s2, tb_par;
    bit junk_mode = 0;
    bit wrong_mode = 0;

    always @(negedge clk) begin
        if (!rst && cmd_valid && n_cmds < 256) begin
            lg_code[n_cmds] = cmd_code;
            lg_tag[n_cmds]  = cmd_tag;
            lg_size[n_cmds] = cmd_size;
            lg_addr[n_cmds] = cmd_addr;
            lg_ok[n_cmds]   = (cmd_code_par == ~^cmd_code) && (cmd_tag_par == ~^cmd_tag) &&
                              (cmd_addr_par == ~^cmd_addr) && cmd_abort == 0 && cmd_ctx == 0;
            n_cmds++;
        end
    end

    task automatic drive_beat(input logic [7:0] tg, input logic [5:0] ad, input logic [511:0] d);
        wbuf_valid = 1'b1; wbuf_tag = tg; wbuf_addr = ad; wbuf_data = d;
        @(negedge clk);
        wbuf_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic [7:0] tg);
        rsp_valid = 1'b1; rsp_tag = tg;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic serve(input int i);
        repeat (2) @(negedge clk);
        if (lg_code[i] == 8'h0A) begin
            if (lg_tag[i] == 8'd0) begin
                if (wrong_mode) begin
                    send_rsp(8'd3);
                    repeat (4) @(negedge clk);
                    chk(n_cmds == i + 1, "R9 wrong tag advanced", 64'(n_cmds), 64'(i + 1));
                end
                drive_beat(8'd0, 6'd0, {swap8(tb_size), swap8(tb_s1), swap8(tb_s2), swap8(tb_par), {8{32'hdeadbeef}}});
            end else begin
                if (junk_mode) drive_beat(lg_tag[i], 6'd0, ~line_data(lg_addr[i], 0));
                drive_beat(lg_tag[i], 6'd1, line_data(lg_addr[i], 1));
                drive_beat(lg_tag[i], 6'd0, line_data(lg_addr[i], 0));
            end
            send_rsp(lg_tag[i]);
        end else begin
            for (int h = 0; h < 2; h++) begin
                rbuf_req = 1'b1; rbuf_tag = lg_tag[i]; rbuf_addr = 6'(h);
                @(negedge clk);
                rbuf_req = 1'b0;
                #1;
                if (h == 0) lg_wd0[i] = rbuf_data; else lg_wd1[i] = rbuf_data;
                chk(rbuf_par == ~^rbuf_data, "R10 fetch parity", 64'(rbuf_par), 64'(~^rbuf_data));
            end
            send_rsp(lg_tag[i]);
        end
    endtask

    initial begin : host
        forever begin
            @(negedge clk);
            if (srv_head < n_cmds) begin
                srv_busy = 1;
                serve(srv_head);
                srv_head++;
                srv_busy = 0;
            end
        end
    end

    task automatic wait_idle();
        while (!(srv_head == n_cmds && !srv_busy)) @(negedge clk);
    endtask

    task automatic do_reset();
        enable = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_cmd(input int i, input logic [7:0] code, input logic [7:0] tg,
                           input logic [11:0] sz, input logic [63:0] ad, input string req);
        chk({lg_code[i], lg_tag[i], lg_size[i]} == {code, tg, sz}, req,
            64'({lg_code[i], lg_tag[i], lg_size[i]}), 64'({code, tg, sz}));
        chk(lg_addr[i] == ad, req, lg_addr[i], ad);
    endtask

    // Runs one job and checks every command and every fetched half against the requirements.
    task automatic run_job(input logic [63:0] dp, input logic [63:0] sz, input logic [63:0] a1,
                           input logic [63:0] a2, input logic [63:0] ap, input bit junk,
                           input bit wrong, input bit pause, input string first_req);
        int base, lines, exp_n, snap, idx;
        bit all_ok;
        do_reset();
        wait_idle();
        desc_ptr = dp; tb_size = sz; tb_s1 = a1; tb_s2 = a2; tb_par = ap;
        junk_mode = junk; wrong_mode = wrong;
        lines = (sz == 0) ? 1 : int'((sz + 127) / 128);
        exp_n = 3 * lines + 2;
        base = n_cmds;
        enable = 1'b1;
        if (pause) begin
            repeat (12) @(negedge clk);
            enable = 1'b0;
            @(negedge clk); #1;
            snap = n_cmds;
            repeat (10) @(negedge clk);
            chk(n_cmds == snap, "R11 command while disabled", 64'(n_cmds), 64'(snap));
            enable = 1'b1;
        end
        while (!(n_cmds >= base + exp_n && srv_head == n_cmds && !srv_busy)) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(n_cmds == base + exp_n, "R8 commands after done", 64'(n_cmds - base), 64'(exp_n));
        idx = base;
        chk_cmd(idx, 8'h0A, 8'd0, 12'd32, dp, first_req);
        idx++;
        for (int l = 0; l < lines; l++) begin
            logic [63:0] o;
            o = 64'(128 * l);
            chk_cmd(idx,     8'h0A, 8'd1, 12'd128, a1 + o, l == 0 ? "R3 stripe1 read / R2" : "R7 stripe1 step");
            chk_cmd(idx + 1, 8'h0A, 8'd2, 12'd128, a2 + o, l == 0 ? "R3 stripe2 read / R2" : "R7 stripe2 step");
            chk_cmd(idx + 2, 8'h0D, 8'd3, 12'd128, ap + o, l == 0 ? "R5 parity write" : "R7 parity step");
            for (int h = 0; h < 2; h++) begin
                logic [511:0] e, a;
                e = line_data(a1 + o, h) ^ line_data(a2 + o, h);
                a = (h == 0) ? lg_wd0[idx + 2] : lg_wd1[idx + 2];
                chk(a == e, junk ? "R4 last beat kept / R6 xor" : "R6 xor half", a[63:0], e[63:0]);
            end
            idx += 3;
        end
        chk_cmd(idx, 8'h0D, 8'd4, 12'd8, dp + 64'd32, "R8 done write");
        chk(lg_wd0[idx] == 512'd1 && lg_wd1[idx] == 512'd0, "R8 flag data", lg_wd0[idx][63:0], 64'd1);
        all_ok = 1;
        for (int k = base; k < base + exp_n; k++) all_ok &= lg_ok[k];
        chk(all_ok, "R10 command parity/ties", 64'(all_ok), 64'd1);
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk(cmd_valid == 1'b0, "R1 idle after reset", 64'(cmd_valid), 64'd0);
        chk(cmd_abort == 0 && cmd_ctx == 0, "R10 tie-offs", 64'({cmd_abort, cmd_ctx}), 64'd0);
        chk(rbuf_latency == 4'd1, "R6 latency", 64'(rbuf_latency), 64'd1);
        repeat (20) @(negedge clk);
        chk(n_cmds == 0, "R11 disabled after reset", 64'(n_cmds), 64'd0);
    endtask

    task automatic t_single_line();
        run_job(64'h0000_7f00_1234_5000, 64'd100, 64'h0000_7f00_2000_0000,
                64'h0000_7f00_3000_0080, 64'h0000_7f00_4000_0100, 0, 0, 0, "R1 descriptor read");
    endtask

    task automatic t_multi_line();
        run_job(64'h0000_1111_0000_0040, 64'd300, 64'h0123_4567_89ab_c000,
                64'h0fed_cba9_8765_4000, 64'h0000_5555_aaaa_0000, 1, 1, 0, "R1 descriptor read");
    endtask

    task automatic t_size_zero();
        run_job(64'h0000_0000_0000_8000, 64'd0, 64'h0000_0000_0001_0000,
                64'h0000_0000_0002_0000, 64'h0000_0000_0003_0000, 0, 0, 0, "R7 zero size desc");
    endtask

    task automatic t_pause();
        run_job(64'h0000_0a0a_0000_0000, 64'd256, 64'h0000_0b0b_0000_0000,
                64'h0000_0c0c_0000_0000, 64'h0000_0d0d_0000_0000, 0, 0, 1, "R1 descriptor read");
    endtask

    task automatic t_reset_mid();
        do_reset();
        wait_idle();
        desc_ptr = 64'h0000_0909_0000_0000; tb_size = 64'd1000;
        tb_s1 = 64'h0000_0101_0000_0000; tb_s2 = 64'h0000_0202_0000_0000; tb_par = 64'h0000_0303_0000_0000;
        junk_mode = 0; wrong_mode = 0;
        enable = 1'b1;
        repeat (60) @(negedge clk);
        run_job(64'h0000_0e0e_0000_0000, 64'd129, 64'h0000_0f0f_0000_0000,
                64'h0000_1010_0000_0000, 64'h0000_1212_0000_0000, 0, 0, 0, "R12 restart desc read");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_single_line();
        t_multi_line();
        t_size_zero();
        t_pause();
        t_reset_mid();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule